// File: doc/BRIEF.md
# Light-Load Power-Save Mode Controller

This block decides whether a buck regulator switches in fixed-frequency PWM or in a discontinuous, constant-peak-current power-save mode. It sees the switching clock as a one-cycle tick in the system clock domain. It also takes digital flags from analog comparators outside the block: a light-load flag, a feedback-below-reference flag and a feedback-droop flag (output about 1.5 % under regulation). It further takes the level of the mode-select pin, a soft-start-complete qualifier and a fault-shutdown flag.

The controller enters power-save mode after a run of consecutive light-load switching ticks. In that mode it fires an on-pulse each time feedback falls below the reference. If the output has not fallen for a programmable number of system clocks, it requests a forced cycle that sinks inductor current, which keeps the switching rate above the audible band. A droop, loss of the mode-select level, loss of the soft-start qualifier or a fault returns the controller to PWM.

Top module: `psm_mode_ctrl`

## Requirements
- R1: With power-save allowed, `psm_o` rises at the clock edge where `sw_tick_i` samples `light_load_i` high for the ENTRY_RUN-th consecutive tick (default 8). Clock cycles without a tick neither advance nor break the run. A tick with `light_load_i` low restarts the run.
- R2: While `psm_o` is high and `fault_i` is low, `on_pulse_o` is high for exactly the one cycle in which `fb_below_ref_i` is high and was low in the previous cycle. `on_pulse_o` is never high while `psm_o` is low.
- R3: While `psm_o` is high, `forced_cycle_o` is high for one cycle when TIMEOUT_CLKS cycles have passed since the last on-pulse or forced cycle without a new on-pulse. If neither has happened yet, it is high in cycle TIMEOUT_CLKS-1 counted from the first power-save cycle as 0. It never coincides with `on_pulse_o`.
- R4: A cycle in power-save mode with `fb_droop_i` high makes `psm_o` low from the next clock edge.
- R5: `psm_sel_i` low keeps the controller in PWM and returns it to PWM at the next edge. A light-load run seen while `psm_sel_i` is low does not count.
- R6: `ss_done_i` low blocks power-save mode in the same way as R5.
- R7: Each return to PWM clears the light-load run, so re-entry needs a fresh run of ENTRY_RUN ticks.
- R8: `fault_i` high masks `on_pulse_o` and `forced_cycle_o` in the same cycle, forces PWM at the next edge and clears the run and timeout counters.
- R9: After reset `psm_o`, `on_pulse_o` and `forced_cycle_o` are low and the previous-feedback state is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_tick_i | input | 1 | One-cycle pulse per switching period |
| light_load_i | input | 1 | Load below half the ripple current |
| fb_below_ref_i | input | 1 | Feedback below reference |
| fb_droop_i | input | 1 | Feedback about 1.5 % below regulation |
| psm_sel_i | input | 1 | Mode-select pin level; high permits power-save |
| ss_done_i | input | 1 | Soft-start complete |
| fault_i | input | 1 | Fault shutdown |
| psm_o | output | 1 | High in power-save mode |
| on_pulse_o | output | 1 | On-pulse trigger in power-save mode |
| forced_cycle_o | output | 1 | Anti-audible forced-cycle request |

## Verification
The bench targets the boundary of the entry run. Seven light-load ticks, then a heavy-load tick, must not enter power-save mode, and ticks spaced by idle cycles must still count. An off-by-one filter would enter a tick early or late, and a filter that counts clocks instead of ticks would enter early. It checks the exact cycle of the forced cycle, and that an on-pulse restarts the timeout. A timer that free-runs would fire a forced cycle too soon after a pulse. It also checks that a run built up before an exit is not reused, and that a level-sensitive pulse detector would show up as repeated pulses while feedback stays low. A long pseudo-random sweep compares every output in every cycle against a model built from the requirements.

// File: rtl/psm_pkg.sv
package psm_pkg;
  typedef enum logic {MODE_PWM = 1'b0, MODE_PSM = 1'b1} mode_e;
endpackage

// File: rtl/psm_run_filter.sv
module psm_run_filter #(
  parameter int unsigned ENTRY_RUN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  input  logic light_i,
  output logic enter_o
);
  localparam int unsigned CW = (ENTRY_RUN > 1) ? $clog2(ENTRY_RUN) : 1;
  localparam logic [CW-1:0] LAST = CW'(ENTRY_RUN - 1);

  logic [CW-1:0] run_q;

  assign enter_o = !clear_i && tick_i && light_i && (run_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (clear_i || enter_o) run_q <= '0;
    else if (tick_i)             run_q <= light_i ? run_q + 1'b1 : '0;
  end
endmodule

// File: rtl/psm_edge_det.sv
module psm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic gate_i,
  output logic fall_edge_o
);
  logic prev_q;

  assign fall_edge_o = gate_i && level_i && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end
endmodule

// File: rtl/psm_quiet_timer.sv
module psm_quiet_timer #(
  parameter int unsigned TIMEOUT_CLKS = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pulse_i,
  output logic expire_o
);
  localparam int unsigned TW = (TIMEOUT_CLKS > 1) ? $clog2(TIMEOUT_CLKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CLKS - 1);

  logic [TW-1:0] tmr_q;

  assign expire_o = run_i && !pulse_i && (tmr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tmr_q <= '0;
    else if (!run_i || pulse_i || expire_o) tmr_q <= '0;
    else                                  tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/psm_mode_ctrl.sv
module psm_mode_ctrl
  import psm_pkg::*;
#(
  parameter int unsigned ENTRY_RUN    = 8,
  parameter int unsigned TIMEOUT_CLKS = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_tick_i,
  input  logic light_load_i,
  input  logic fb_below_ref_i,
  input  logic fb_droop_i,
  input  logic psm_sel_i,
  input  logic ss_done_i,
  input  logic fault_i,
  output logic psm_o,
  output logic on_pulse_o,
  output logic forced_cycle_o
);
  mode_e mode_q, mode_d;
  logic  allow, in_psm, enter, pulse, expire;

  assign allow  = psm_sel_i && ss_done_i && !fault_i;
  assign in_psm = (mode_q == MODE_PSM);

  psm_run_filter #(.ENTRY_RUN(ENTRY_RUN)) i_run (
    .clk_i, .rst_ni,
    .clear_i (!allow || in_psm),
    .tick_i  (sw_tick_i),
    .light_i (light_load_i),
    .enter_o (enter)
  );

  psm_edge_det i_edge (
    .clk_i, .rst_ni,
    .level_i     (fb_below_ref_i),
    .gate_i      (in_psm && !fault_i),
    .fall_edge_o (pulse)
  );

  psm_quiet_timer #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) i_tmr (
    .clk_i, .rst_ni,
    .run_i    (in_psm && !fault_i),
    .pulse_i  (pulse),
    .expire_o (expire)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_PWM: if (enter) mode_d = MODE_PSM;
      MODE_PSM: if (fb_droop_i || !allow) mode_d = MODE_PWM;
      default:  mode_d = MODE_PWM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_PWM;
    else         mode_q <= mode_d;
  end

  assign psm_o          = in_psm;
  assign on_pulse_o     = pulse;
  assign forced_cycle_o = expire;
endmodule

// File: rtl/psm_mode_ctrl_chk.sv
module psm_mode_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_tick_i,
  input logic light_load_i,
  input logic fb_below_ref_i,
  input logic fb_droop_i,
  input logic psm_sel_i,
  input logic ss_done_i,
  input logic fault_i,
  input logic psm_o,
  input logic on_pulse_o,
  input logic forced_cycle_o
);
  AST_ENTRY_ON_LIGHT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(psm_o) |-> $past(sw_tick_i && light_load_i)); // R1
  AST_PULSE_ONLY_PSM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_pulse_o |-> (psm_o && fb_below_ref_i)); // R2
  AST_PULSE_NOT_REPEATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_pulse_o |=> !on_pulse_o); // R2
  AST_FORCED_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    forced_cycle_o |-> (psm_o && !on_pulse_o)); // R3
  AST_DROOP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psm_o && fb_droop_i) |=> !psm_o); // R4
  AST_NO_PSM_WITHOUT_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psm_sel_i |=> !psm_o); // R5
  AST_NO_PSM_BEFORE_SS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_done_i |=> !psm_o); // R6
  AST_FAULT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |-> (!on_pulse_o && !forced_cycle_o)); // R8
  AST_FAULT_PWM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !psm_o); // R8
endmodule

bind psm_mode_ctrl psm_mode_ctrl_chk i_chk (.*);

// File: tb/test_psm_mode_ctrl.sv
module test_psm_mode_ctrl;
  localparam int N = 8;
  localparam int T = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, ll = 0, fb = 0, droop = 0, sel = 0, ss = 0, fault = 0;
  logic psm, pulse, forced;
  int checks = 0, fails = 0;
  bit m_mode = 0, m_prev = 0;
  int m_cnt = 0, m_tmr = 0;

  always #5 clk = ~clk;

  psm_mode_ctrl #(.ENTRY_RUN(N), .TIMEOUT_CLKS(T)) i_psm_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sw_tick_i(tick), .light_load_i(ll),
    .fb_below_ref_i(fb), .fb_droop_i(droop), .psm_sel_i(sel), .ss_done_i(ss),
    .fault_i(fault), .psm_o(psm), .on_pulse_o(pulse), .forced_cycle_o(forced));

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // inputs already set after a negedge; compare, then advance the model at the edge
  task automatic step(string tag);
    bit allow, e_pulse, e_forced, enter;
    #1;
    allow    = sel && ss && !fault;
    e_pulse  = m_mode && !fault && fb && !m_prev;
    e_forced = m_mode && !fault && !e_pulse && (m_tmr == T-1);
    chk(tag, psm, m_mode, "psm_o");
    chk(tag, pulse, e_pulse, "on_pulse_o");
    chk(tag, forced, e_forced, "forced_cycle_o");
    enter = !m_mode && allow && tick && ll && (m_cnt == N-1);
    @(posedge clk);
    if (!m_mode || fault || e_pulse || e_forced) m_tmr = 0; else m_tmr++;
    if (!allow || m_mode || enter) m_cnt = 0;
    else if (tick) m_cnt = ll ? m_cnt + 1 : 0;
    m_prev = fb;
    if (m_mode) begin if (droop || !allow) m_mode = 0; end
    else if (enter) m_mode = 1;
    @(negedge clk);
  endtask

  task automatic ticks(string tag, int n, bit light, int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1; ll = light; step(tag);
      tick = 0;
      for (int g = 0; g < gap; g++) step(tag);
    end
    tick = 0;
  endtask

  task automatic expect_mode(string tag, bit m);
    #1; chk(tag, psm, m, "mode after sequence");
  endtask

  initial begin : watchdog
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    fb = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R9", psm, 1'b0, "psm_o in reset");
    chk("R9", pulse, 1'b0, "on_pulse_o in reset");
    chk("R9", forced, 1'b0, "forced_cycle_o in reset");
    rst_n = 1; fb = 0;
    @(negedge clk);
    step("R9");

    // R6: soft-start not done blocks entry
    sel = 1; ss = 0;
    ticks("R6", 20, 1, 0);
    expect_mode("R6", 0);
    ss = 1;
    // R5: select low blocks entry
    sel = 0;
    ticks("R5", 20, 1, 1);
    expect_mode("R5", 0);
    sel = 1;

    // R1: 7 light ticks then one heavy tick, no entry
    ticks("R1", 7, 1, 0);
    ticks("R1", 1, 0, 0);
    ticks("R1", 7, 1, 2);
    expect_mode("R1", 0);
    ticks("R1", 1, 1, 3);
    expect_mode("R1", 1);

    // R3: no feedback fall, forced cycles repeat
    for (int i = 0; i < 3*T+2; i++) step("R3");
    // R2: feedback crossings give one pulse each; pulse restarts the timeout
    for (int k = 0; k < 6; k++) begin
      fb = 1; for (int i = 0; i < 3 + k; i++) step("R2");
      fb = 0; for (int i = 0; i < 2 + k; i++) step("R2");
    end
    fb = 1; for (int i = 0; i < 2*T; i++) step("R3");
    fb = 0; step("R3");

    // R4: droop exit
    droop = 1; step("R4"); droop = 0; step("R4");
    expect_mode("R4", 0);
    // R2: no pulses in PWM
    fb = 1; step("R2"); fb = 0; step("R2"); fb = 1; step("R2");

    // R7: fresh run needed after exit
    ticks("R7", 7, 1, 0);
    expect_mode("R7", 0);
    ticks("R7", 1, 1, 0);
    expect_mode("R7", 1);
    // R5: select low exits
    sel = 0; step("R5"); sel = 1; step("R5");
    expect_mode("R5", 0);
    ticks("R6", 8, 1, 0);
    // R6: soft-start drop exits
    ss = 0; step("R6"); ss = 1; step("R6");
    expect_mode("R6", 0);
    ticks("R8", 5, 1, 0);
    // R8: fault mid-run clears counter
    fault = 1; step("R8"); fault = 0;
    ticks("R8", 3, 1, 0);
    expect_mode("R8", 0);
    ticks("R8", 5, 1, 0);
    expect_mode("R8", 1);
    fb = 0; step("R8");
    fault = 1; fb = 1; step("R8"); fault = 0; step("R8");
    expect_mode("R8", 0);

    // pseudo-random sweep against the model
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 6000; i++) begin
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick  = lfsr[0] & lfsr[1];
        ll    = lfsr[2] | lfsr[3] | lfsr[4];
        fb    = (i % 7 < 3) ^ (lfsr[5] & lfsr[6] & lfsr[7]);
        droop = (lfsr[15:8] == 8'h3C);
        sel   = (lfsr[15:9] != 7'h11);
        ss    = (lfsr[14:8] != 7'h22);
        fault = (lfsr[15:6] == 10'h155);
        step("R2");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule